// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the digital divider pair that sits in front of the phase comparator of an integer-N synthesizer. On the RF side, a prescaler that divides by either P or P+1 drives two counters. A main counter sets the number of prescaler periods in one output cycle, to B. A swallow counter sets how many of those periods run at P+1, to A. The RF clock is therefore divided by P*B+A. On the reference side, a separate programmable counter divides the reference clock by R. Each side emits a one-cycle pulse per completed division, and the phase detector downstream consumes both pulses.

Ratios are written as a control word. The RF fields (prescaler select, A, B) are written with a strobe in the RF clock domain. The reference field is written with its own strobe in the reference clock domain. A word written in the middle of a cycle is held in a shadow register. It is applied only when the running cycle completes, so no output period mixes two ratios. An RF word that breaks the legality rules is dropped, and an error flag is raised.

A retiming mode adds one register on the RF clock to the divided output, so the output edge is launched straight from a flop rather than from counter decode. The modulus decision for every prescaler period is always a registered reload value. `resync_en` is meant to be changed only while `rst` is held. `rst` is synchronous and is sampled in both clock domains.

Top module: `pulse_swallow_div`

## Requirements
- R1: With an accepted RF word, consecutive `fb_pulse` pulses are exactly P*B+A RF clock cycles apart.
- R2: An RF write with `cfg_a` >= `cfg_b` is not loaded. It sets `cfg_err` on the following cycle, and the running ratio is kept.
- R3: An RF write whose total P*B+A is below P*(P-1) is rejected the same way as in R2. For P=8 this floor is 56, and a total of exactly 56 is accepted.
- R4: `cfg_psel` selects the prescaler modulus: 0 gives P=8, 1 gives P=16, 2 gives P=32, 3 gives P=64.
- R5: The reference ratio is `ref_div_m1`+1, which spans 1 to 16384, and `ref_pulse` pulses once every R reference cycles. The reset default is R=4. With R=1, `ref_pulse` stays high on every reference cycle.
- R6: A newly written ratio takes effect only at the end of the cycle that is running when it is written. The interval that contains the write keeps the old ratio, and the next interval uses the new one.
- R7: With `resync_en`=1, `fb_pulse` is delayed by exactly one RF cycle compared with `resync_en`=0, and the spacing is unchanged.
- R8: `fb_pulse` is high for exactly one RF cycle per completed division.
- R9: Reset clears `fb_pulse` and `cfg_err`, loads the default word (P=8, B=8, A=1, ratio 65) and starts a fresh cycle in the P+1 phase. With `resync_en`=0, the first pulse is seen 64 RF edges after reset is released.
- R10: A legal RF write clears `cfg_err` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_clk | input | 1 | RF input clock being divided |
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high, used in both domains |
| resync_en | input | 1 | 1 = output retimed by one RF-clock register |
| cfg_wr | input | 1 | Write strobe for the RF fields (rf_clk domain) |
| cfg_psel | input | 2 | Prescaler modulus select (0:8, 1:16, 2:32, 3:64) |
| cfg_a | input | A_W | Swallow count A |
| cfg_b | input | B_W | Main count B |
| ref_wr | input | 1 | Write strobe for the reference ratio (ref_clk domain) |
| ref_div_m1 | input | R_W | Reference ratio minus one |
| fb_pulse | output | 1 | Divided RF pulse, one rf_clk cycle wide |
| ref_pulse | output | 1 | Divided reference pulse, one ref_clk cycle wide |
| cfg_err | output | 1 | Most recent RF write was rejected |

## Verification
On every RF cycle, the assertions check three things. The divided pulse never lasts two cycles. Reset leaves the output and error flag low. Writes with A not below B, or with a total below the P=8 floor, raise the error flag, while a legal P=8 write clears it. Only the directed scenarios can show the exact spacing P*B+A for each prescaler select. They also show the boundary-only adoption of new words, the one-cycle offset of the retimed output, and the reference divider's range, including full-rate pass-through at R=1.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [1:0] {
    PSEL_8  = 2'd0,
    PSEL_16 = 2'd1,
    PSEL_32 = 2'd2,
    PSEL_64 = 2'd3
  } psel_e;

  localparam int PC_W = 7;

  // Prescaler modulus from select field: 8 << sel
  function automatic logic [PC_W-1:0] p_of(input logic [1:0] sel);
    p_of = 7'd8 << sel;
  endfunction
endpackage

// File: rtl/fb_cfg_gate.sv
module fb_cfg_gate
  import psd_pkg::*;
#(
  parameter int         A_W      = 8,
  parameter int         B_W      = 13,
  parameter logic [1:0] DEF_PSEL = 2'd0,
  parameter int         DEF_A    = 1,
  parameter int         DEF_B    = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [1:0]     psel,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic           take,
  output logic [1:0]     act_psel,
  output logic [1:0]     nxt_psel,
  output logic [A_W-1:0] nxt_a,
  output logic [B_W-1:0] nxt_b,
  output logic           err
);
  localparam int T_W = B_W + PC_W + 1;

  logic [T_W-1:0] total, floor_v;
  logic           legal;
  logic [A_W-1:0] act_a, pend_a;
  logic [B_W-1:0] act_b, pend_b;
  logic [1:0]     pend_psel;
  logic           pend_v;

  always_comb begin
    total = (T_W'(b) << (3'd3 + {1'b0, psel})) + T_W'(a);
    case (psel)
      2'd0:    floor_v = T_W'(56);
      2'd1:    floor_v = T_W'(240);
      2'd2:    floor_v = T_W'(992);
      default: floor_v = T_W'(4032);
    endcase
    legal = (T_W'(a) < T_W'(b)) && (total >= floor_v);
  end

  assign nxt_psel = pend_v ? pend_psel : act_psel;
  assign nxt_a    = pend_v ? pend_a    : act_a;
  assign nxt_b    = pend_v ? pend_b    : act_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_psel  <= DEF_PSEL;
      act_a     <= A_W'(DEF_A);
      act_b     <= B_W'(DEF_B);
      pend_psel <= '0;
      pend_a    <= '0;
      pend_b    <= '0;
      pend_v    <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (take) begin
        act_psel <= nxt_psel;
        act_a    <= nxt_a;
        act_b    <= nxt_b;
        pend_v   <= 1'b0;
      end
      if (wr) begin
        if (legal) begin
          pend_psel <= psel;
          pend_a    <= a;
          pend_b    <= b;
          pend_v    <= 1'b1;
          err       <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swallow_core.sv
module swallow_core
  import psd_pkg::*;
#(
  parameter int         A_W      = 8,
  parameter int         B_W      = 13,
  parameter logic [1:0] DEF_PSEL = 2'd0,
  parameter int         DEF_A    = 1,
  parameter int         DEF_B    = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     act_psel,
  input  logic [1:0]     nxt_psel,
  input  logic [A_W-1:0] nxt_a,
  input  logic [B_W-1:0] nxt_b,
  output logic           last
);
  logic [PC_W-1:0] pre_cnt;
  logic [A_W-1:0]  a_rem;
  logic [B_W-1:0]  b_rem;
  logic [PC_W-1:0] p_cur, p_nxt, p_def;
  logic            prd_end;

  assign p_cur   = p_of(act_psel);
  assign p_nxt   = p_of(nxt_psel);
  assign p_def   = p_of(DEF_PSEL);
  assign prd_end = (pre_cnt == '0);
  assign last    = prd_end && (b_rem == B_W'(1));

  // pre_cnt reload value is the registered modulus choice for the next period
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem   <= A_W'(DEF_A);
      b_rem   <= B_W'(DEF_B);
      pre_cnt <= (DEF_A != 0) ? p_def : p_def - PC_W'(1);
    end else if (last) begin
      a_rem   <= nxt_a;
      b_rem   <= nxt_b;
      pre_cnt <= (nxt_a != '0) ? p_nxt : p_nxt - PC_W'(1);
    end else if (prd_end) begin
      b_rem   <= b_rem - B_W'(1);
      a_rem   <= (a_rem != '0) ? a_rem - A_W'(1) : '0;
      pre_cnt <= (a_rem > A_W'(1)) ? p_cur : p_cur - PC_W'(1);
    end else begin
      pre_cnt <= pre_cnt - PC_W'(1);
    end
  end
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int R_W      = 14,
  parameter int DEF_R_M1 = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [R_W-1:0] div_m1,
  output logic           pulse
);
  logic [R_W-1:0] r_act, r_pend, r_cnt, r_nxt;
  logic           pend_v;

  assign pulse = (r_cnt == '0);
  assign r_nxt = pend_v ? r_pend : r_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_act  <= R_W'(DEF_R_M1);
      r_cnt  <= R_W'(DEF_R_M1);
      r_pend <= '0;
      pend_v <= 1'b0;
    end else begin
      if (pulse) begin
        r_cnt  <= r_nxt;
        r_act  <= r_nxt;
        pend_v <= 1'b0;
      end else begin
        r_cnt <= r_cnt - R_W'(1);
      end
      if (wr) begin
        r_pend <= div_m1;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int         A_W      = 8,
  parameter int         B_W      = 13,
  parameter int         R_W      = 14,
  parameter logic [1:0] DEF_PSEL = 2'd0,
  parameter int         DEF_A    = 1,
  parameter int         DEF_B    = 8,
  parameter int         DEF_R_M1 = 3
) (
  input  logic           rf_clk,
  input  logic           ref_clk,
  input  logic           rst,
  input  logic           resync_en,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_psel,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  input  logic           ref_wr,
  input  logic [R_W-1:0] ref_div_m1,
  output logic           fb_pulse,
  output logic           ref_pulse,
  output logic           cfg_err
);
  logic [1:0]     act_psel, nxt_psel;
  logic [A_W-1:0] nxt_a;
  logic [B_W-1:0] nxt_b;
  logic           last_raw, last_q;

  fb_cfg_gate #(
    .A_W(A_W), .B_W(B_W), .DEF_PSEL(DEF_PSEL), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_gate (
    .clk(rf_clk), .rst(rst), .wr(cfg_wr), .psel(cfg_psel), .a(cfg_a), .b(cfg_b),
    .take(last_raw), .act_psel(act_psel), .nxt_psel(nxt_psel),
    .nxt_a(nxt_a), .nxt_b(nxt_b), .err(cfg_err)
  );

  swallow_core #(
    .A_W(A_W), .B_W(B_W), .DEF_PSEL(DEF_PSEL), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_core (
    .clk(rf_clk), .rst(rst), .act_psel(act_psel), .nxt_psel(nxt_psel),
    .nxt_a(nxt_a), .nxt_b(nxt_b), .last(last_raw)
  );

  ref_divider #(
    .R_W(R_W), .DEF_R_M1(DEF_R_M1)
  ) u_ref (
    .clk(ref_clk), .rst(rst), .wr(ref_wr), .div_m1(ref_div_m1), .pulse(ref_pulse)
  );

  // Retiming flop: output launched directly from an rf_clk register
  always_ff @(posedge rf_clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= last_raw;
  end

  assign fb_pulse = resync_en ? last_q : last_raw;
endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk #(
  parameter int A_W = 8,
  parameter int B_W = 13
) (
  input logic           rf_clk,
  input logic           rst,
  input logic           cfg_wr,
  input logic [1:0]     cfg_psel,
  input logic [A_W-1:0] cfg_a,
  input logic [B_W-1:0] cfg_b,
  input logic           fb_pulse,
  input logic           cfg_err
);
  // R8
  pulse_one_wide_chk: assert property (@(posedge rf_clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);

  // R9
  reset_quiet_chk: assert property (@(posedge rf_clk)
    rst |=> (!fb_pulse && !cfg_err));

  // R2
  swallow_order_chk: assert property (@(posedge rf_clk) disable iff (rst)
    (cfg_wr && (int'(cfg_a) >= int'(cfg_b))) |=> cfg_err);

  // R3
  ratio_floor_chk: assert property (@(posedge rf_clk) disable iff (rst)
    (cfg_wr && cfg_psel == 2'd0 && int'(cfg_b) < 7) |=> cfg_err);

  // R10
  legal_clears_chk: assert property (@(posedge rf_clk) disable iff (rst)
    (cfg_wr && cfg_psel == 2'd0 && int'(cfg_b) >= 7 && int'(cfg_a) < int'(cfg_b))
      |=> !cfg_err);
endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .rf_clk(rf_clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_psel(cfg_psel),
  .cfg_a(cfg_a), .cfg_b(cfg_b), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
);

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;
  localparam int A_W = 8;
  localparam int B_W = 13;
  localparam int R_W = 14;

  logic           rf_clk = 1'b0;
  logic           ref_clk = 1'b0;
  logic           rst = 1'b1;
  logic           resync_en = 1'b0;
  logic           cfg_wr = 1'b0;
  logic [1:0]     cfg_psel = '0;
  logic [A_W-1:0] cfg_a = '0;
  logic [B_W-1:0] cfg_b = '0;
  logic           ref_wr = 1'b0;
  logic [R_W-1:0] ref_div_m1 = '0;
  logic           fb_pulse, ref_pulse, cfg_err;

  int checks = 0;
  int fails  = 0;

  always #10 rf_clk = ~rf_clk;
  always #8  ref_clk = ~ref_clk;

  pulse_swallow_div u_pulse_swallow_div (
    .rf_clk(rf_clk), .ref_clk(ref_clk), .rst(rst), .resync_en(resync_en),
    .cfg_wr(cfg_wr), .cfg_psel(cfg_psel), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .ref_wr(ref_wr), .ref_div_m1(ref_div_m1),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fb_cnt(output int n);
    n = 0;
    do begin
      @(posedge rf_clk); @(negedge rf_clk); n++;
    end while (!fb_pulse && n < 9000);
    if (n >= 9000) begin
      checks++; fails++;
      $display("FAIL watchdog: fb_pulse missing, actual %0d expected <9000", n);
    end
  endtask

  task automatic ref_cnt(output int n);
    n = 0;
    do begin
      @(posedge ref_clk); @(negedge ref_clk); n++;
    end while (!ref_pulse && n < 20000);
    if (n >= 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: ref_pulse missing, actual %0d expected <20000", n);
    end
  endtask

  task automatic fb_write(input int ps, input int a, input int b);
    cfg_psel = 2'(ps); cfg_a = A_W'(a); cfg_b = B_W'(b); cfg_wr = 1'b1;
    @(posedge rf_clk); @(negedge rf_clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ref_write(input int m1);
    ref_div_m1 = R_W'(m1); ref_wr = 1'b1;
    @(posedge ref_clk); @(negedge ref_clk);
    ref_wr = 1'b0;
  endtask

  // R9 / R7 / R8: reset state, first pulse timing, width and default ratio
  task automatic t_reset(input logic rs, input int exp_first, input string req);
    int n, m;
    @(negedge rf_clk);
    rst = 1'b1; resync_en = rs;
    repeat (10) @(negedge rf_clk);
    chk("R9 fb_pulse low in reset", int'(fb_pulse), 0);
    chk("R9 cfg_err low in reset", int'(cfg_err), 0);
    rst = 1'b0;
    fb_cnt(n);
    chk(req, n, exp_first);
    @(posedge rf_clk); @(negedge rf_clk);
    chk("R8 pulse one cycle wide", int'(fb_pulse), 0);
    fb_cnt(m);
    chk("R1 default ratio 65", 1 + m, 65);
  endtask

  // R6 + R1/R4: switch ratio, old kept for the running cycle
  task automatic t_switch(input int ps, input int a, input int b,
                          input int old_n, input int new_n, input string req);
    int n, m;
    fb_cnt(n);
    fb_write(ps, a, b);
    chk("R10 legal write leaves cfg_err low", int'(cfg_err), 0);
    if (fb_pulse) m = 0; else fb_cnt(m);
    chk("R6 running cycle keeps old ratio", 1 + m, old_n);
    fb_cnt(m);
    chk(req, m, new_n);
    fb_cnt(m);
    chk(req, m, new_n);
  endtask

  // R2 / R3: rejected word flags error and leaves ratio untouched
  task automatic t_reject(input int ps, input int a, input int b,
                          input int keep_n, input string req);
    int n, m;
    fb_cnt(n);
    fb_write(ps, a, b);
    chk({req, " cfg_err set"}, int'(cfg_err), 1);
    if (fb_pulse) m = 0; else fb_cnt(m);
    chk({req, " ratio kept"}, 1 + m, keep_n);
    fb_cnt(m);
    chk({req, " ratio kept"}, m, keep_n);
  endtask

  // R5: reference divider switch
  task automatic t_ref(input int m1, input int old_n, input string req);
    int n, m;
    ref_cnt(n);
    ref_write(m1);
    if (ref_pulse) m = 0; else ref_cnt(m);
    chk("R5 running ref cycle keeps old ratio", 1 + m, old_n);
    if (m1 == 0) begin
      for (int i = 0; i < 3; i++) begin
        @(posedge ref_clk); @(negedge ref_clk);
        chk("R5 R=1 passes reference at full rate", int'(ref_pulse), 1);
      end
    end else begin
      ref_cnt(m);
      chk(req, m, m1 + 1);
    end
  endtask

  initial begin
    #3900000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    t_reset(1'b0, 64, "R9 first pulse after 64 edges");
    t_switch(0, 0, 7, 65, 56, "R3 floor ratio 56 accepted (R1)");
    t_switch(0, 3, 8, 56, 67, "R1 ratio 8*8+3");
    t_switch(1, 5, 15, 67, 245, "R4 psel=1 P=16 ratio 245");
    t_switch(2, 0, 31, 245, 992, "R4 psel=2 P=32 ratio 992");
    t_switch(3, 1, 63, 992, 4033, "R4 psel=3 P=64 ratio 4033");
    t_switch(0, 7, 8, 4033, 71, "R1 ratio 8*8+7");
    t_reject(0, 9, 9, 71, "R2 A equal B");
    t_reject(0, 12, 9, 71, "R2 A above B");
    t_switch(0, 1, 9, 71, 73, "R10 legal write after error (R1)");
    t_reject(0, 5, 6, 73, "R3 total 53 below 56");
    t_reject(1, 13, 14, 73, "R3 P=16 total 237 below 240");
    t_switch(1, 0, 15, 73, 240, "R3 P=16 floor 240 accepted");
    t_reset(1'b1, 65, "R7 retimed first pulse one cycle later");
    t_switch(0, 2, 7, 65, 58, "R7 retimed spacing unchanged");
    fb_cnt(n);
    @(posedge rf_clk); @(negedge rf_clk);
    chk("R8 retimed pulse one cycle wide", int'(fb_pulse), 0);
    begin
      int m;
      ref_cnt(m);
      ref_cnt(m);
      chk("R5 default reference ratio 4", m, 4);
    end
    t_ref(6, 4, "R5 reference ratio 7");
    t_ref(0, 7, "R5 reference ratio 1");
    t_ref(16383, 1, "R5 reference ratio 16384");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule